// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block forms a 20-bit physical memory address from a 16-bit segment base and a 16-bit offset. The base is extended with four zero bits below its least significant bit and added to the offset. Any carry out of the top bit is dropped, so addresses wrap within 00000h..FFFFFh. Each segment therefore covers a 64 KB window.

The caller names the kind of register that supplies the offset. The block picks the segment that goes with that source: code for fetches, stack for stack and frame pointers, data for index and general registers, and extra for string destinations. An override input can substitute any of the four segments, except on instruction fetches and string destinations. The four segment bases live in the block, and a single write port updates them. A parameter chooses between a registered output (the default) and a purely combinational one.

Top module: `seg_addr_gen`

## Requirements
- R1: When OUT_REG=1, `addr_o` equals ((base << 4) + offset) mod 2^20. The base is that of the selected segment, and the address appears one clock edge after its inputs are applied. Its low four bits always equal the offset's low four bits.
- R2: A segment write (`seg_we_i`=1) stores `seg_wdata_i` into the segment named by `seg_wsel_i` at the next clock edge. Segment codes are 0 extra, 1 code, 2 stack and 3 data.
- R3: A segment that is not written keeps its value.
- R4: While `rst_ni` is low, `addr_o` is 00000h, the code segment base is FFFFh and the other three bases are 0000h.
- R5: Source code 0 (instruction pointer) always uses the code segment, and the override is ignored.
- R6: Source codes 1 (stack pointer) and 2 (base pointer) use the stack segment unless overridden.
- R7: Source code 4 (destination index) with `str_dst_i`=1 always uses the extra segment, and the override is ignored.
- R8: Source codes 3 (source index), 4 with `str_dst_i`=0, and 5 to 7 (general register) use the data segment unless overridden.
- R9: With `ovr_en_i`=1, sources other than those in R5 and R7 use the segment named by `ovr_seg_i`.
- R10: A carry out of bit 19 is discarded. For example, base FFFFh with offset FFFFh gives 0FFEFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| seg_we_i | input | 1 | Segment write enable |
| seg_wsel_i | input | 2 | Segment to write (0 extra, 1 code, 2 stack, 3 data) |
| seg_wdata_i | input | 16 | Base value to write |
| off_i | input | 16 | Offset (logical address) |
| src_i | input | 3 | Offset source code |
| str_dst_i | input | 1 | Destination index is a string destination |
| ovr_en_i | input | 1 | Segment override enable |
| ovr_seg_i | input | 2 | Override segment code |
| addr_o | output | 20 | Physical address |

## Verification
A segment write lands at the first clock edge. An address that depends on that write therefore appears at `addr_o` one edge later, and the bench waits for both edges before it compares. Each address vector is driven on a falling edge and sampled on the next falling edge, which leaves exactly one rising edge for the output register. The sweep covers every source code, the string flag, the override enable and every override segment, at offsets that exercise the low nibble, the carry chain and the 20-bit wrap. It repeats this over two sets of segment bases.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
  parameter int unsigned SEG_W  = 16;
  parameter int unsigned OFF_W  = 16;
  parameter int unsigned SHIFT  = 4;
  parameter int unsigned NSEG   = 4;
  localparam int unsigned ADDR_W = SEG_W + SHIFT;
  localparam int unsigned SEL_W  = $clog2(NSEG);

  typedef enum logic [SEL_W-1:0] {
    SEG_EXTRA = 2'd0,
    SEG_CODE  = 2'd1,
    SEG_STACK = 2'd2,
    SEG_DATA  = 2'd3
  } seg_e;

  typedef enum logic [2:0] {
    SRC_IP  = 3'd0,
    SRC_SP  = 3'd1,
    SRC_BP  = 3'd2,
    SRC_SI  = 3'd3,
    SRC_DI  = 3'd4,
    SRC_GPR = 3'd5
  } src_e;
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
  import seg_addr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [SEL_W-1:0] wsel_i,
  input  logic [SEG_W-1:0] wdata_i,
  input  logic [SEL_W-1:0] rsel_i,
  output logic [SEG_W-1:0] rdata_o
);
  logic [SEG_W-1:0] seg_q [NSEG];

  for (genvar i = 0; i < NSEG; i++) begin : g_seg
    localparam logic [SEG_W-1:0] RST_VAL = (i == int'(SEG_CODE)) ? '1 : '0;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 seg_q[i] <= RST_VAL;
      else if (we_i && wsel_i == SEL_W'(i))        seg_q[i] <= wdata_i;
    end

    p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(we_i && wsel_i == SEL_W'(i)) |=> $stable(seg_q[i]));
  end

  assign rdata_o = seg_q[rsel_i];

  p_write_lands_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> seg_q[$past(wsel_i)] == $past(wdata_i));
endmodule

// File: rtl/seg_select.sv
module seg_select
  import seg_addr_pkg::*;
(
  input  logic [2:0]       src_i,
  input  logic             str_dst_i,
  input  logic             ovr_en_i,
  input  logic [SEL_W-1:0] ovr_seg_i,
  output logic [SEL_W-1:0] sel_o
);
  seg_e dflt;
  logic locked;

  always_comb begin
    locked = 1'b0;
    unique case (src_i)
      SRC_IP:         begin dflt = SEG_CODE; locked = 1'b1; end
      SRC_SP, SRC_BP: dflt = SEG_STACK;
      SRC_DI: begin
        dflt   = str_dst_i ? SEG_EXTRA : SEG_DATA;
        locked = str_dst_i;
      end
      default:        dflt = SEG_DATA;
    endcase
  end

  assign sel_o = (ovr_en_i && !locked) ? ovr_seg_i : dflt;
endmodule

// File: rtl/seg_adder.sv
module seg_adder
  import seg_addr_pkg::*;
(
  input  logic [SEG_W-1:0]  base_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [ADDR_W-1:0] addr_o
);
  // carry out of the top bit is dropped by the width
  assign addr_o = {base_i, {SHIFT{1'b0}}} + ADDR_W'(off_i);
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        seg_we_i,
  input  logic [1:0]  seg_wsel_i,
  input  logic [15:0] seg_wdata_i,
  input  logic [15:0] off_i,
  input  logic [2:0]  src_i,
  input  logic        str_dst_i,
  input  logic        ovr_en_i,
  input  logic [1:0]  ovr_seg_i,
  output logic [19:0] addr_o
);
  logic [SEL_W-1:0]  sel;
  logic [SEG_W-1:0]  base;
  logic [ADDR_W-1:0] addr_d;

  seg_regfile i_regs (
    .clk_i, .rst_ni,
    .we_i(seg_we_i), .wsel_i(seg_wsel_i), .wdata_i(seg_wdata_i),
    .rsel_i(sel), .rdata_o(base)
  );

  seg_select i_sel (
    .src_i, .str_dst_i, .ovr_en_i, .ovr_seg_i, .sel_o(sel)
  );

  seg_adder i_add (.base_i(base), .off_i(off_i), .addr_o(addr_d));

  if (OUT_REG) begin : g_reg
    logic [ADDR_W-1:0] addr_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) addr_q <= '0;
      else         addr_q <= addr_d;
    end
    assign addr_o = addr_q;
  end else begin : g_comb
    assign addr_o = addr_d;
  end

  p_low_nibble_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_d[SHIFT-1:0] == off_i[SHIFT-1:0]);
  p_fetch_code_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_i == 3'd0 |-> sel == SEG_CODE);
  p_str_extra_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == 3'd4 && str_dst_i) |-> sel == SEG_EXTRA);
  p_stack_dflt_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((src_i == 3'd1 || src_i == 3'd2) && !ovr_en_i) |-> sel == SEG_STACK);
endmodule

// File: tb/test_seg_addr_gen.sv
`timescale 1ns/1ps
module test_seg_addr_gen;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        seg_we = 1'b0;
  logic [1:0]  seg_wsel = '0;
  logic [15:0] seg_wdata = '0;
  logic [15:0] off = '0;
  logic [2:0]  src = '0;
  logic        str_dst = 1'b0;
  logic        ovr_en = 1'b0;
  logic [1:0]  ovr_seg = '0;
  logic [19:0] addr;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;
  logic [15:0] seg_m [4];

  always #2 clk = ~clk;

  seg_addr_gen i_seg_addr_gen (
    .clk_i(clk), .rst_ni(rst_ni),
    .seg_we_i(seg_we), .seg_wsel_i(seg_wsel), .seg_wdata_i(seg_wdata),
    .off_i(off), .src_i(src), .str_dst_i(str_dst),
    .ovr_en_i(ovr_en), .ovr_seg_i(ovr_seg), .addr_o(addr)
  );

  task automatic check(input string req, input logic [19:0] act, input logic [19:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %05h expected %05h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_seg(input logic [2:0] s, input logic sd,
                                         input logic oe, input logic [1:0] os);
    if (s == 3'd0) return 2'd1;            // R5
    if (s == 3'd4 && sd) return 2'd0;      // R7
    if (oe) return os;                     // R9
    if (s == 3'd1 || s == 3'd2) return 2'd2; // R6
    return 2'd3;                           // R8
  endfunction

  function automatic logic [19:0] exp_addr(input logic [15:0] b, input logic [15:0] o);
    logic [20:0] full;
    full = {1'b0, b, 4'h0} + {5'h0, o};
    return full[19:0];                     // R10 drop carry
  endfunction

  task automatic wr_seg(input logic [1:0] s, input logic [15:0] v);
    @(negedge clk);
    seg_we = 1'b1; seg_wsel = s; seg_wdata = v;
    @(negedge clk);
    seg_we = 1'b0;
    seg_m[s] = v;
  endtask

  task automatic probe(input string req, input logic [2:0] s, input logic sd,
                       input logic oe, input logic [1:0] os, input logic [15:0] o);
    src = s; str_dst = sd; ovr_en = oe; ovr_seg = os; off = o;
    @(negedge clk);
    check(req, addr, exp_addr(seg_m[exp_seg(s, sd, oe, os)], o));
  endtask

  task automatic sweep();
    logic [15:0] offs [5];
    offs[0] = 16'h0000; offs[1] = 16'h0001; offs[2] = 16'h000F;
    offs[3] = 16'h8001; offs[4] = 16'hFFFF;
    for (int s = 0; s < 8; s++)
      for (int sd = 0; sd < 2; sd++)
        for (int oe = 0; oe < 2; oe++)
          for (int os = 0; os < 4; os++)
            for (int k = 0; k < 5; k++)
              probe("R1/R5/R6/R7/R8/R9", 3'(s), 1'(sd), 1'(oe), 2'(os), offs[k]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R4 addr in reset", addr, 20'h00000);
    seg_m[0] = 16'h0000; seg_m[1] = 16'hFFFF; seg_m[2] = 16'h0000; seg_m[3] = 16'h0000;
    rst_ni = 1'b1;
    @(negedge clk);
    // R4: reset bases observed through the address path
    probe("R4 code base", 3'd0, 1'b0, 1'b0, 2'd0, 16'h0000);
    probe("R4 stack base", 3'd1, 1'b0, 1'b0, 2'd0, 16'h1234);
    probe("R4 data base", 3'd3, 1'b0, 1'b0, 2'd0, 16'h0042);
    probe("R4 extra base", 3'd4, 1'b1, 1'b0, 2'd0, 16'h0007);
    // R2 / R3: single write, others hold
    wr_seg(2'd2, 16'h2000);
    @(negedge clk);
    probe("R2 stack written", 3'd1, 1'b0, 1'b0, 2'd0, 16'h0000);
    probe("R3 code held", 3'd0, 1'b0, 1'b0, 2'd0, 16'h0000);
    probe("R3 data held", 3'd5, 1'b0, 1'b0, 2'd0, 16'h0010);
    // R10 wrap
    wr_seg(2'd3, 16'hFFFF);
    @(negedge clk);
    src = 3'd3; str_dst = 0; ovr_en = 0; off = 16'hFFFF;
    @(negedge clk);
    check("R10 wrap", addr, 20'h0FFEF);
    // set 1
    wr_seg(2'd0, 16'h1234); wr_seg(2'd1, 16'hF000);
    wr_seg(2'd2, 16'h0BAD); wr_seg(2'd3, 16'hABCD);
    @(negedge clk);
    sweep();
    // set 2
    wr_seg(2'd0, 16'hFFFE); wr_seg(2'd1, 16'h0001);
    wr_seg(2'd2, 16'h7FFF); wr_seg(2'd3, 16'h8000);
    @(negedge clk);
    sweep();
    // R1 latency: output follows a change only after one edge
    src = 3'd3; ovr_en = 0; off = 16'h0000;
    @(negedge clk);
    off = 16'h0005;
    #1;
    check("R1 registered, old value", addr, exp_addr(16'h8000, 16'h0000));
    @(negedge clk);
    check("R1 registered, new value", addr, exp_addr(16'h8000, 16'h0005));
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end
endmodule